// File: doc/BRIEF.md
# SDRAM Per-Bank State Tracker

This block watches the command bus of a four-bank synchronous DRAM and keeps, for every bank, a model of where that bank is in its life cycle. On each rising clock edge it decodes the command from chip select, RAS, CAS and WE, and uses A10 and the bank address. A bank moves through these states: idle, opening a row, row open, bursting, closing, and the auto-precharge variants. Each move is timed by a clock-count parameter. Alongside the banks it follows the device-wide condition: normal running, the quiet window after a refresh, self refresh and power-down.

Any command that the tracked state does not allow is reported. The report is a single-clock pulse one edge later, carrying the number of the bank responsible. An offending command never changes the model. The tracker sits beside a memory controller or a memory model as a protocol monitor. It never drives the bus, and it stores no array data.

Top module: `sdt_bank_tracker`

## Requirements
- R1: A command is taken only at an edge where CKE was high at the previous edge. With chip select low, {RAS,CAS,WE} decodes as follows: 011 opens a row, 101 reads, 100 writes, 010 precharges, 001 refreshes, 000 sets the mode, 110 stops a burst and 111 is a NOP. With chip select high the edge is a deselect and has no effect.
- R2: After reset every bank reads idle (code 0). `illegal_o`, `refresh_o`, `self_refresh_o` and `power_down_o` are low, and `all_idle_o` is high.
- R3: An open-row command to an idle bank shows code 1 (opening) and then code 2 (open). A read or write to that bank is legal from T_RCD clocks after the open and illegal before then.
- R4: An illegal command raises `illegal_o` for the clock that follows its edge, with `illegal_bank_o` naming the bank. It changes no bank state and no global state.
- R5: A read or write without A10 shows code 3 for BURST_LEN clocks, then returns to code 2. A burst-stop command returns every bursting bank to code 2 at once. An open-row command to a bank that is not idle is illegal.
- R6: A read or write with A10 high shows code 5 for BURST_LEN clocks, then code 6 for T_RP clocks. The next open-row command to that bank is legal from BURST_LEN+T_RP clocks after the read or write.
- R7: While an auto-precharge is pending on a bank, any open-row, read, write or precharge addressed to it is illegal. This includes a precharge with A10 high.
- R8: A precharge with A10 low closes only the addressed bank: code 4 for T_RP clocks, then code 0. A burst in another bank carries on.
- R9: A precharge with A10 high closes every bank that is opening, open or bursting.
- R10: Refresh, mode set, self-refresh entry and power-down entry are legal only when every bank is idle. Otherwise the command is illegal and the lowest-numbered bank that is not idle is reported.
- R11: After a refresh, or after leaving self refresh, `refresh_o` is high. For the next T_RC-1 edges only NOP or deselect is legal. The edge T_RC clocks after the refresh or the exit accepts any command.
- R12: A refresh with CKE falling enters self refresh (`self_refresh_o` high). Commands are ignored while CKE stays low, and CKE rising leaves the state.
- R13: A NOP or deselect with CKE falling enters power-down (`power_down_o` high). Commands are ignored inside it, and CKE rising returns to normal running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| a10 | input | 1 | Auto-precharge / all-bank select |
| ba | input | BA_W (2) | Bank address |
| illegal_o | output | 1 | One-clock pulse for a disallowed command |
| illegal_bank_o | output | BA_W (2) | Bank blamed for the pulse |
| bank_state_o | output | 3*NUM_BANKS (12) | Bank b state code at bits [3b+2:3b] |
| all_idle_o | output | 1 | Every bank reads idle |
| refresh_o | output | 1 | Refresh quiet window in progress |
| self_refresh_o | output | 1 | Device in self refresh |
| power_down_o | output | 1 | Device in power-down |

## Verification
An error in a bank timer shows up on the first command that lands on the edge where that timer ends. Such a command is reported one clock too early or too late, so `illegal_o` shows the error on the next clock. `bank_state_o` also shows the wrong code on the clock where the bank should have moved. A bad global state shows up at the first command issued in the quiet window after a refresh or a self-refresh exit. It also shows up as an entry to self refresh or power-down that is granted or refused wrongly, which `self_refresh_o` and `power_down_o` show one edge after the entry.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [3:0] {
    CMD_DESEL, CMD_NOP, CMD_ACT, CMD_READ, CMD_WRITE,
    CMD_PRE, CMD_REF, CMD_MRS, CMD_TBST
  } sdt_cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE       = 3'd0,
    BK_OPENING    = 3'd1,
    BK_OPEN       = 3'd2,
    BK_BURST      = 3'd3,
    BK_CLOSING    = 3'd4,
    BK_AP_BURST   = 3'd5,
    BK_AP_CLOSING = 3'd6
  } bank_st_e;

  typedef enum logic [1:0] {
    GL_RUN, GL_REFRESH, GL_SELF, GL_DOWN
  } glob_st_e;

  // Counter load for a window of 'clocks' edges, ending when the counter reads zero
  function automatic int span_load(input int clocks);
    return (clocks > 1) ? clocks - 1 : 0;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic sdt_cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                          input logic cas_n, input logic we_n);
    if (cs_n) return CMD_DESEL;
    case ({ras_n, cas_n, we_n})
      3'b011:  return CMD_ACT;
      3'b101:  return CMD_READ;
      3'b100:  return CMD_WRITE;
      3'b010:  return CMD_PRE;
      3'b001:  return CMD_REF;
      3'b000:  return CMD_MRS;
      3'b110:  return CMD_TBST;
      default: return CMD_NOP;
    endcase
  endfunction

endpackage

// File: rtl/sdt_cmd_decode.sv
module sdt_cmd_decode
  import sdt_pkg::*;
(
  input  logic     cs_n,
  input  logic     ras_n,
  input  logic     cas_n,
  input  logic     we_n,
  output sdt_cmd_e cmd,
  output logic     quiet
);
  always_comb begin
    cmd   = decode_cmd(cs_n, ras_n, cas_n, we_n);
    quiet = (cmd == CMD_DESEL) || (cmd == CMD_NOP);
  end
endmodule

// File: rtl/sdt_bank_fsm.sv
module sdt_bank_fsm
  import sdt_pkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  sdt_cmd_e cmd,
  input  logic     sel,
  input  logic     a10,
  input  logic     accept,
  output bank_st_e st,
  output logic     idle_rdy,
  output logic     ap_pend,
  output logic     bad
);
  localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(span_load(T_RCD));
  localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(span_load(T_RP));
  localparam logic [CNT_W-1:0] LD_BL  = CNT_W'(span_load(BURST_LEN));

  logic [CNT_W-1:0] cnt, cnt_n;
  bank_st_e         st_n;
  logic             cnt_zero, rw_rdy, pre_hit;

  always_comb begin
    cnt_zero = (cnt == '0);
    idle_rdy = (st == BK_IDLE) ||
               (((st == BK_CLOSING) || (st == BK_AP_CLOSING)) && cnt_zero);
    rw_rdy   = (st == BK_OPEN) || (st == BK_BURST) ||
               ((st == BK_OPENING) && cnt_zero);
    ap_pend  = (st == BK_AP_BURST) || ((st == BK_AP_CLOSING) && !cnt_zero);
    pre_hit  = sel || a10;
    case (cmd)
      CMD_ACT:              bad = sel && !idle_rdy;
      CMD_READ, CMD_WRITE:  bad = sel && !rw_rdy;
      CMD_PRE:              bad = pre_hit && ap_pend;
      default:              bad = 1'b0;
    endcase
  end

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    // timers run on their own
    case (st)
      BK_OPENING, BK_BURST: begin
        if (cnt_zero) st_n = BK_OPEN;
        else          cnt_n = cnt - 1'b1;
      end
      BK_AP_BURST: begin
        if (cnt_zero) begin
          st_n  = BK_AP_CLOSING;
          cnt_n = LD_RP;
        end else cnt_n = cnt - 1'b1;
      end
      BK_CLOSING, BK_AP_CLOSING: begin
        if (cnt_zero) st_n = BK_IDLE;
        else          cnt_n = cnt - 1'b1;
      end
      default: ;
    endcase
    // accepted commands override the timers
    if (accept) begin
      case (cmd)
        CMD_ACT: if (sel) begin
          st_n  = BK_OPENING;
          cnt_n = LD_RCD;
        end
        CMD_READ, CMD_WRITE: if (sel) begin
          st_n  = a10 ? BK_AP_BURST : BK_BURST;
          cnt_n = LD_BL;
        end
        CMD_PRE: if (pre_hit && ((st == BK_OPENING) || (st == BK_OPEN) ||
                                 (st == BK_BURST))) begin
          st_n  = BK_CLOSING;
          cnt_n = LD_RP;
        end
        CMD_TBST: if (st == BK_BURST) st_n = BK_OPEN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= BK_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/sdt_global_fsm.sv
module sdt_global_fsm
  import sdt_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int T_RC  = 7
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cke,
  input  logic     go_refresh,
  input  logic     go_self,
  input  logic     go_down,
  output logic     cke_q,
  output glob_st_e gst,
  output logic     block
);
  localparam logic [CNT_W-1:0] LD_RC = CNT_W'(span_load(T_RC));

  logic [CNT_W-1:0] cnt, cnt_n;
  glob_st_e         gst_n;
  logic             cke_rise;

  always_comb begin
    block    = (gst == GL_REFRESH) && (cnt != '0);
    cke_rise = !cke_q && cke;
    gst_n    = gst;
    cnt_n    = cnt;
    case (gst)
      GL_REFRESH: begin
        if (cnt == '0) gst_n = GL_RUN;
        else           cnt_n = cnt - 1'b1;
      end
      GL_SELF: if (cke_rise) begin
        gst_n = GL_REFRESH;
        cnt_n = LD_RC;
      end
      GL_DOWN: if (cke_rise) gst_n = GL_RUN;
      default: ;
    endcase
    if (go_refresh) begin
      gst_n = GL_REFRESH;
      cnt_n = LD_RC;
    end else if (go_self) begin
      gst_n = GL_SELF;
    end else if (go_down) begin
      gst_n = GL_DOWN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gst   <= GL_RUN;
      cnt   <= '0;
      cke_q <= 1'b1;
    end else begin
      gst   <= gst_n;
      cnt   <= cnt_n;
      cke_q <= cke;
    end
  end
endmodule

// File: rtl/sdt_bank_tracker.sv
module sdt_bank_tracker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int T_RCD     = 3,
  parameter int T_RP      = 3,
  parameter int T_RC      = 7,
  parameter int BURST_LEN = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cke,
  input  logic                   cs_n,
  input  logic                   ras_n,
  input  logic                   cas_n,
  input  logic                   we_n,
  input  logic                   a10,
  input  logic [BA_W-1:0]        ba,
  output logic                   illegal_o,
  output logic [BA_W-1:0]        illegal_bank_o,
  output logic [3*NUM_BANKS-1:0] bank_state_o,
  output logic                   all_idle_o,
  output logic                   refresh_o,
  output logic                   self_refresh_o,
  output logic                   power_down_o
);
  localparam int SPAN_MAX = max4(T_RCD, T_RP, T_RC, BURST_LEN);
  localparam int CNT_W    = $clog2(SPAN_MAX + 1);

  sdt_cmd_e cmd;
  glob_st_e gst;
  logic     cmd_quiet, cke_q, glob_block;

  // named internal events, observed by the bound checker
  logic                 cmd_live, cmd_illegal, cmd_accept;
  logic                 glob_bad, idle_bad, ck_fall, needs_idle;
  logic                 go_refresh, go_self, go_down;
  logic [NUM_BANKS-1:0] bank_bad, bank_idle_rdy, bank_ap, bank_is_idle;
  logic [BA_W-1:0]      first_busy, first_bad, offender;
  bank_st_e             bank_st [NUM_BANKS];

  sdt_cmd_decode u_decode (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cmd(cmd), .quiet(cmd_quiet)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (ba == BA_W'(b));
    sdt_bank_fsm #(
      .CNT_W(CNT_W), .T_RCD(T_RCD), .T_RP(T_RP), .BURST_LEN(BURST_LEN)
    ) u_bank (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .sel(sel), .a10(a10),
      .accept(cmd_accept), .st(bank_st[b]), .idle_rdy(bank_idle_rdy[b]),
      .ap_pend(bank_ap[b]), .bad(bank_bad[b])
    );
    assign bank_state_o[3*b +: 3] = bank_st[b];
    assign bank_is_idle[b]        = (bank_st[b] == BK_IDLE);
  end

  sdt_global_fsm #(.CNT_W(CNT_W), .T_RC(T_RC)) u_global (
    .clk(clk), .rst_n(rst_n), .cke(cke), .go_refresh(go_refresh),
    .go_self(go_self), .go_down(go_down), .cke_q(cke_q), .gst(gst),
    .block(glob_block)
  );

  always_comb begin
    first_busy = '0;
    first_bad  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (!bank_idle_rdy[b]) first_busy = BA_W'(b);
      if (bank_bad[b])       first_bad  = BA_W'(b);
    end
  end

  always_comb begin
    cmd_live    = cke_q;
    ck_fall     = cke_q && !cke;
    needs_idle  = (cmd == CMD_REF) || (cmd == CMD_MRS) || (cmd_quiet && ck_fall);
    glob_bad    = glob_block && (!cmd_quiet || ck_fall);
    idle_bad    = needs_idle && !(&bank_idle_rdy);
    cmd_illegal = cmd_live && (glob_bad || idle_bad || (|bank_bad));
    cmd_accept  = cmd_live && !cmd_illegal;
    offender    = glob_bad ? ba : (idle_bad ? first_busy : first_bad);
    go_refresh  = cmd_accept && (cmd == CMD_REF) && cke;
    go_self     = cmd_accept && (cmd == CMD_REF) && !cke;
    go_down     = cmd_accept && cmd_quiet && ck_fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      illegal_o      <= 1'b0;
      illegal_bank_o <= '0;
    end else begin
      illegal_o      <= cmd_illegal;
      illegal_bank_o <= cmd_illegal ? offender : '0;
    end
  end

  assign all_idle_o     = &bank_is_idle;
  assign refresh_o      = (gst == GL_REFRESH);
  assign self_refresh_o = (gst == GL_SELF);
  assign power_down_o   = (gst == GL_DOWN);

endmodule

// File: rtl/sdt_tracker_checker.sv
module sdt_tracker_checker
  import sdt_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input sdt_cmd_e             cmd,
  input logic [BA_W-1:0]      ba,
  input logic                 cke_q,
  input logic                 cmd_live,
  input logic                 cmd_quiet,
  input logic                 cmd_illegal,
  input logic                 cmd_accept,
  input logic                 glob_block,
  input logic [NUM_BANKS-1:0] bank_ap,
  input logic                 illegal_o,
  input logic                 all_idle_o,
  input logic                 refresh_o,
  input logic                 self_refresh_o,
  input logic                 power_down_o
);
  AST_ILLEGAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(cmd_live)) else $error("illegal pulse without live command"); // R4

  AST_ASLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |-> (!cmd_illegal && !cmd_accept)) else $error("command taken with clock disabled"); // R12

  AST_REFRESH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (glob_block && cmd_live && !cmd_quiet) |-> cmd_illegal) else $error("command accepted in refresh window"); // R11

  AST_SELF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(self_refresh_o) |-> all_idle_o) else $error("self refresh with open bank"); // R10

  AST_DOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(power_down_o) |-> all_idle_o) else $error("power-down with open bank"); // R13

  AST_GLOBAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({refresh_o, self_refresh_o, power_down_o})) else $error("global states overlap"); // R12

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_ap
    AST_AP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_ap[b] && cmd_live && (ba == BA_W'(b)) &&
       ((cmd == CMD_ACT) || (cmd == CMD_READ) || (cmd == CMD_WRITE) || (cmd == CMD_PRE)))
      |-> cmd_illegal) else $error("command reached bank with pending auto-precharge"); // R7
  end
endmodule

bind sdt_bank_tracker sdt_tracker_checker #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_checker (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .cke_q(cke_q), .cmd_live(cmd_live),
  .cmd_quiet(cmd_quiet), .cmd_illegal(cmd_illegal), .cmd_accept(cmd_accept),
  .glob_block(glob_block), .bank_ap(bank_ap), .illegal_o(illegal_o),
  .all_idle_o(all_idle_o), .refresh_o(refresh_o), .self_refresh_o(self_refresh_o),
  .power_down_o(power_down_o)
);

// File: tb/tb_sdt_bank_tracker.sv
module tb_sdt_bank_tracker;
  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] C_DES  = 4'b1011;
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_ACT  = 4'b0011;
  localparam logic [3:0] C_RD   = 4'b0101;
  localparam logic [3:0] C_WR   = 4'b0100;
  localparam logic [3:0] C_PRE  = 4'b0010;
  localparam logic [3:0] C_REF  = 4'b0001;
  localparam logic [3:0] C_MRS  = 4'b0000;
  localparam logic [3:0] C_TBST = 4'b0110;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0]  ba = 2'd0;
  logic        illegal_o, all_idle_o, refresh_o, self_refresh_o, power_down_o;
  logic [1:0]  illegal_bank_o;
  logic [11:0] bank_state_o;

  int checks = 0, fails = 0, cyc = 0;

  typedef struct { int due; logic ill; int bank; string tag; } exp_t;
  exp_t q[$];

  sdt_bank_tracker dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba), .illegal_o(illegal_o),
    .illegal_bank_o(illegal_bank_o), .bank_state_o(bank_state_o),
    .all_idle_o(all_idle_o), .refresh_o(refresh_o),
    .self_refresh_o(self_refresh_o), .power_down_o(power_down_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pop expectations as their cycle arrives
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (illegal_o !== e.ill || (e.ill && illegal_bank_o !== 2'(e.bank))) begin
        fails++;
        $display("FAIL %s: illegal=%0b bank=%0d, expected illegal=%0b bank=%0d",
                 e.tag, illegal_o, illegal_bank_o, e.ill, e.bank);
      end
    end
  end

  task automatic drive(input logic [3:0] c, input int b, input logic a, input logic ck,
                       input logic ei, input int eb, input string tag);
    exp_t e;
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba  = 2'(b);
    a10 = a;
    cke = ck;
    e.due = cyc + 1; e.ill = ei; e.bank = eb; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(C_NOP, 0, 1'b0, 1'b1, 1'b0, 0, "NOP quiet");
  endtask

  task automatic chk_st(input int b, input int exp, input string tag);
    int act;
    act = int'(bank_state_o[b*3 +: 3]);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: bank%0d state=%0d, expected %0d", tag, b, act, exp);
    end
  endtask

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b, expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    for (int b = 0; b < 4; b++) chk_st(b, 0, "R2 reset bank");
    chk_bit(illegal_o, 1'b0, "R2 reset illegal");
    chk_bit(all_idle_o, 1'b1, "R2 reset all idle");
    chk_bit(refresh_o | self_refresh_o | power_down_o, 1'b0, "R2 reset global");
    rst_n = 1'b1;

    // R1 deselect with an open-row pattern has no effect
    drive(C_DES, 0, 1'b0, 1'b1, 1'b0, 0, "R1 deselect");
    nop(1);
    chk_st(0, 0, "R1 deselect no effect");

    // R3 / R5 / R4: open, early read, burst, open-on-open
    drive(C_ACT, 0, 1'b0, 1'b1, 1'b0, 0, "R3 open bank0");
    drive(C_RD,  0, 1'b0, 1'b1, 1'b1, 0, "R3 read before T_RCD");
    chk_st(0, 1, "R3 opening");
    nop(1);
    drive(C_RD,  0, 1'b0, 1'b1, 1'b0, 0, "R3 read at T_RCD");
    nop(1);
    chk_st(0, 3, "R5 bursting");
    nop(3);
    chk_st(0, 3, "R5 last burst clock");
    drive(C_ACT, 0, 1'b0, 1'b1, 1'b1, 0, "R5 open on open bank");
    chk_st(0, 2, "R5 burst ended");
    nop(1);
    chk_st(0, 2, "R4 illegal leaves state");

    // R5 burst stop
    drive(C_WR,   0, 1'b0, 1'b1, 1'b0, 0, "R5 write");
    drive(C_TBST, 0, 1'b0, 1'b1, 1'b0, 0, "R5 burst stop");
    chk_st(0, 3, "R5 write bursting");
    nop(1);
    chk_st(0, 2, "R5 stop returns open");

    // R8 single precharge, other bank burst continues
    drive(C_ACT, 1, 1'b0, 1'b1, 1'b0, 0, "R8 open bank1");
    nop(2);
    drive(C_RD,  1, 1'b0, 1'b1, 1'b0, 0, "R8 read bank1");
    drive(C_PRE, 0, 1'b0, 1'b1, 1'b0, 0, "R8 close bank0");
    nop(1);
    chk_st(0, 4, "R8 bank0 closing");
    chk_st(1, 3, "R8 bank1 burst continues");
    nop(4);
    chk_st(0, 0, "R8 bank0 idle");
    chk_st(1, 2, "R8 bank1 open");

    // R10 refresh and mode set need all idle
    drive(C_REF, 0, 1'b0, 1'b1, 1'b1, 1, "R10 refresh with bank1 open");
    drive(C_MRS, 0, 1'b0, 1'b1, 1'b1, 1, "R10 mode set with bank1 open");
    nop(1);

    // R9 precharge all
    drive(C_ACT, 2, 1'b0, 1'b1, 1'b0, 0, "R9 open bank2");
    drive(C_PRE, 0, 1'b1, 1'b1, 1'b0, 0, "R9 precharge all");
    nop(1);
    chk_st(1, 4, "R9 bank1 closing");
    chk_st(2, 4, "R9 bank2 closing");
    nop(3);
    chk_bit(all_idle_o, 1'b1, "R9 all idle");

    // R11 refresh quiet window
    drive(C_REF, 0, 1'b0, 1'b1, 1'b0, 0, "R11 refresh");
    drive(C_ACT, 0, 1'b0, 1'b1, 1'b1, 0, "R11 open in window");
    chk_bit(refresh_o, 1'b1, "R11 refresh flag");
    nop(4);
    drive(C_ACT, 3, 1'b0, 1'b1, 1'b1, 3, "R11 last blocked edge");
    drive(C_ACT, 3, 1'b0, 1'b1, 1'b0, 0, "R11 first free edge");
    nop(1);
    chk_st(3, 1, "R11 open after window");
    chk_bit(refresh_o, 1'b0, "R11 window over");
    nop(2);

    // R6 / R7 auto-precharge
    drive(C_RD,  3, 1'b1, 1'b1, 1'b0, 0, "R6 read with auto-precharge");
    drive(C_RD,  3, 1'b0, 1'b1, 1'b1, 3, "R7 read during auto-precharge");
    chk_st(3, 5, "R6 auto burst");
    drive(C_PRE, 3, 1'b0, 1'b1, 1'b1, 3, "R7 precharge during auto-precharge");
    drive(C_PRE, 0, 1'b1, 1'b1, 1'b1, 3, "R7 precharge-all during auto-precharge");
    nop(2);
    chk_st(3, 6, "R6 auto closing");
    drive(C_ACT, 3, 1'b0, 1'b1, 1'b1, 3, "R6 open before BL+T_RP");
    drive(C_ACT, 3, 1'b0, 1'b1, 1'b0, 0, "R6 open at BL+T_RP");
    nop(1);
    chk_st(3, 1, "R6 reopened");

    // R10 / R13 power-down refused with open bank
    drive(C_NOP, 0, 1'b0, 1'b0, 1'b1, 3, "R10 power-down with bank3 open");
    drive(C_NOP, 0, 1'b0, 1'b1, 1'b0, 0, "R13 cke back");
    nop(1);
    chk_bit(power_down_o, 1'b0, "R13 refused entry");
    drive(C_PRE, 0, 1'b1, 1'b1, 1'b0, 0, "R9 close bank3");
    nop(4);
    chk_bit(all_idle_o, 1'b1, "R9 idle before power-down");

    // R13 power-down accepted, commands ignored
    drive(C_NOP, 0, 1'b0, 1'b0, 1'b0, 0, "R13 enter power-down");
    drive(C_ACT, 0, 1'b0, 1'b0, 1'b0, 0, "R13 ignored open");
    drive(C_NOP, 0, 1'b0, 1'b1, 1'b0, 0, "R13 exit");
    chk_bit(power_down_o, 1'b1, "R13 in power-down");
    chk_st(0, 0, "R13 ignored command");
    nop(1);
    chk_bit(power_down_o, 1'b0, "R13 left power-down");

    // R12 self refresh, then R11 window after exit
    drive(C_REF, 0, 1'b0, 1'b0, 1'b0, 0, "R12 enter self refresh");
    drive(C_ACT, 1, 1'b0, 1'b0, 1'b0, 0, "R12 ignored open");
    drive(C_NOP, 0, 1'b0, 1'b0, 1'b0, 0, "R12 hold");
    chk_bit(self_refresh_o, 1'b1, "R12 in self refresh");
    chk_st(1, 0, "R12 ignored command");
    drive(C_NOP, 0, 1'b0, 1'b1, 1'b0, 0, "R12 exit");
    drive(C_ACT, 1, 1'b0, 1'b1, 1'b1, 1, "R11 open after exit");
    chk_bit(refresh_o, 1'b1, "R11 window after exit");
    nop(5);
    drive(C_ACT, 1, 1'b0, 1'b1, 1'b0, 0, "R11 open T_RC after exit");
    nop(1);
    chk_st(1, 1, "R11 bank1 opening");
    nop(2);

    while (q.size() > 0) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule